// File: doc/BRIEF.md
# Command-Driven Endpoint Buffer Controller

This block sits between a microcontroller and one endpoint FIFO with its DMA settings. The microcontroller writes 8-bit command codes through a one-cycle strobe. The block decodes each code and applies it to the FIFO pointers, the occupancy count, the packet-valid flag and the DMA mode registers. Data moves in and out through plain push and pop ports. The commands that change the FIFO state are validate, clear, rewind and full DMA reset.

One command starts a task-file read sweep. The block then presents the task-file register addresses in ascending order, one per clock, and skips two excluded addresses. When the sweep ends it raises a one-cycle interrupt. Commands that arrive during the sweep wait in a single hold slot, where a later write replaces an earlier one. The held command runs once the sweep is over.

Top module: `epbuf_cmd_ctrl`

## Requirements
- R1: After reset, these outputs are zero: `wr_ptr`, `rd_ptr`, `level`, `pkt_valid`, `tf_rd`, `irq`, `cmd_busy`, `dma_mode`, `dma_dir`, `dma_armed` and `illegal_cmd`.
- R2: Pushing writes `push_data` at `wr_ptr`. `pop_data` always shows the entry at `rd_ptr`. Each accepted push or pop advances its pointer by one and wraps from DEPTH-1 to 0, and `level` tracks the occupancy. A push is ignored when `level` equals DEPTH, and a pop is ignored when `level` is 0.
- R3: Code 0x0E sets `pkt_valid` to 1 if `level` is non-zero and to 0 otherwise. A pop that empties the buffer clears `pkt_valid`.
- R4: Code 0x0F sets `wr_ptr`, `rd_ptr`, `level` and `pkt_valid` to 0.
- R5: Code 0x10 sets `wr_ptr` and `rd_ptr` to 0 and leaves `level`, `pkt_valid` and the stored data unchanged, so the next pop returns the entry at index 0.
- R6: Code 0x11 returns every state output listed in R1 to its reset value.
- R7: Codes 0x00 to 0x07 set `dma_mode` to code bits [2:1] (0 generic, 1 UDMA, 2 PIO, 3 MDMA), set `dma_dir` to code bit 0 and set `dma_armed` to 1.
- R8: Code 0x0C starts the task-file sweep. From the cycle after the command, `tf_rd` and `cmd_busy` are high for one cycle per address. `tf_addr` steps upward through 0 to TF_N-1 and skips EXCL_A and EXCL_B.
- R9: `irq` is high for exactly one cycle, the cycle after the last sweep address, and `cmd_busy` is low in that cycle.
- R10: A command written while `cmd_busy` is high does not act during the sweep. Only the last one written is kept, and it takes effect at the clock edge that ends the `irq` cycle.
- R11: The codes 0x08 to 0x0B, 0x0D and 0x12 to 0xFF change no FIFO or DMA state. Each of them sets `illegal_cmd`, which stays set until code 0x11 or reset.
- R12: A push or pop in the same cycle that a command takes effect is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_busy | output | 1 | Task-file sweep in progress |
| push_en | input | 1 | Push request |
| push_data | input | DATA_W | Data to push |
| pop_en | input | 1 | Pop request |
| pop_data | output | DATA_W | Entry at the read pointer |
| wr_ptr | output | AW | Write pointer |
| rd_ptr | output | AW | Read pointer |
| level | output | AW+1 | Occupancy count |
| pkt_valid | output | 1 | Buffer validated as a packet |
| tf_rd | output | 1 | Task-file read strobe |
| tf_addr | output | TF_AW | Task-file register address |
| irq | output | 1 | Sweep-complete pulse |
| dma_mode | output | 2 | Selected DMA mode |
| dma_dir | output | 1 | DMA direction |
| dma_armed | output | 1 | A mode command has been applied |
| illegal_cmd | output | 1 | Sticky reserved-code flag |

## Verification
The assertions check these properties on every cycle:
- `level` never exceeds DEPTH, and `pkt_valid` never stays set on an empty buffer.
- Commands never take effect during a sweep, the sweep never presents an excluded address, and `irq` lasts one cycle and follows the end of `busy`.
- Clear, rewind and DMA reset leave the state R4 to R6 require, and `illegal_cmd` stays set until DMA reset.

Some behaviour only the bench scenarios can show:
- the data order through pointer wraparound;
- that a rewind replays the stored data from index 0;
- that only the last held command survives a sweep;
- that each of the 256 codes decodes to its own effect.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_MODE,
    OP_TFREAD,
    OP_VALIDATE,
    OP_CLEAR,
    OP_RESTART,
    OP_DMARST,
    OP_ILLEGAL
  } op_e;

  localparam logic [7:0] CODE_TFREAD   = 8'h0C;
  localparam logic [7:0] CODE_VALIDATE = 8'h0E;
  localparam logic [7:0] CODE_CLEAR    = 8'h0F;
  localparam logic [7:0] CODE_RESTART  = 8'h10;
  localparam logic [7:0] CODE_DMARST   = 8'h11;

  // Map a raw command code to its operation class.
  function automatic op_e decode_op(input logic [7:0] c);
    op_e r;
    if (c[7:3] == 5'd0) r = OP_MODE;
    else begin
      case (c)
        CODE_TFREAD:   r = OP_TFREAD;
        CODE_VALIDATE: r = OP_VALIDATE;
        CODE_CLEAR:    r = OP_CLEAR;
        CODE_RESTART:  r = OP_RESTART;
        CODE_DMARST:   r = OP_DMARST;
        default:       r = OP_ILLEGAL;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/epbuf_cmd_decode.sv
module epbuf_cmd_decode
  import epbuf_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    op = valid ? decode_op(code) : OP_NONE;
  end
endmodule

// File: rtl/epbuf_fifo.sv
module epbuf_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_blk,
  input  logic              do_clear,
  input  logic              do_restart,
  input  logic              do_validate,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_en,
  output logic [DATA_W-1:0] pop_data,
  output logic [AW-1:0]     wr_ptr,
  output logic [AW-1:0]     rd_ptr,
  output logic [LW-1:0]     level,
  output logic              pkt_valid,
  output logic              push_ok,
  output logic              pop_ok
);
  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok  = push_en && !cmd_blk && (level != LW'(DEPTH));
  assign pop_ok   = pop_en && !cmd_blk && (level != '0);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || do_clear) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      pkt_valid <= 1'b0;
    end else if (do_restart) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (do_validate) pkt_valid <= (level != '0);
      else if (pop_ok && !push_ok && level == LW'(1)) pkt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/epbuf_tf_seq.sv
module epbuf_tf_seq #(
  parameter int TF_N   = 8,
  parameter int EXCL_A = 0,
  parameter int EXCL_B = 7,
  localparam int IW    = $clog2(TF_N + 1),
  localparam int OW    = $clog2(TF_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          irq,
  output logic [OW-1:0] tf_addr
);
  logic [IW-1:0] idx;
  logic [IW-1:0] first_idx;
  logic [IW-1:0] next_idx;
  logic          seq_last;

  // Lowest allowed address at or above 'from'; TF_N when none remains.
  function automatic logic [IW-1:0] tf_scan(input int from);
    logic [IW-1:0] r;
    r = IW'(TF_N);
    for (int a = TF_N - 1; a >= 0; a--) begin
      if (a >= from && a != EXCL_A && a != EXCL_B) r = IW'(a);
    end
    return r;
  endfunction

  always_comb begin
    first_idx = tf_scan(0);
    next_idx  = tf_scan(int'(idx) + 1);
    seq_last  = (next_idx == IW'(TF_N));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      irq  <= 1'b0;
      idx  <= '0;
    end else begin
      irq <= 1'b0;
      if (start && !busy) begin
        if (first_idx == IW'(TF_N)) irq <= 1'b1;
        else begin
          busy <= 1'b1;
          idx  <= first_idx;
        end
      end else if (busy) begin
        if (seq_last) begin
          busy <= 1'b0;
          irq  <= 1'b1;
        end else idx <= next_idx;
      end
    end
  end

  assign tf_addr = idx[OW-1:0];
endmodule

// File: rtl/epbuf_cmd_ctrl.sv
module epbuf_cmd_ctrl
  import epbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int TF_N   = 8,
  parameter int EXCL_A = 0,
  parameter int EXCL_B = 7,
  localparam int AW    = $clog2(DEPTH),
  localparam int TF_AW = $clog2(TF_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_code,
  output logic              cmd_busy,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_en,
  output logic [DATA_W-1:0] pop_data,
  output logic [AW-1:0]     wr_ptr,
  output logic [AW-1:0]     rd_ptr,
  output logic [AW:0]       level,
  output logic              pkt_valid,
  output logic              tf_rd,
  output logic [TF_AW-1:0]  tf_addr,
  output logic              irq,
  output logic [1:0]        dma_mode,
  output logic              dma_dir,
  output logic              dma_armed,
  output logic              illegal_cmd
);
  // Named internal events, also observed by the bound checker.
  logic       tf_busy;
  logic       pend_v;
  logic [7:0] pend_code;
  logic       cmd_exec;
  logic [7:0] exec_code;
  op_e        exec_op;
  logic       push_ok;
  logic       pop_ok;

  assign cmd_exec  = !tf_busy && (pend_v || cmd_wr);
  assign exec_code = pend_v ? pend_code : cmd_code;

  epbuf_cmd_decode dec_i (
    .valid (cmd_exec),
    .code  (exec_code),
    .op    (exec_op)
  );

  // One-deep hold slot: the latest write wins while a command cannot run.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_code <= '0;
    end else if (cmd_wr && (tf_busy || pend_v)) begin
      pend_v    <= 1'b1;
      pend_code <= cmd_code;
    end else if (cmd_exec) begin
      pend_v <= 1'b0;
    end
  end

  epbuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_blk     (cmd_exec),
    .do_clear    (exec_op == OP_CLEAR || exec_op == OP_DMARST),
    .do_restart  (exec_op == OP_RESTART),
    .do_validate (exec_op == OP_VALIDATE),
    .push_en     (push_en),
    .push_data   (push_data),
    .pop_en      (pop_en),
    .pop_data    (pop_data),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .level       (level),
    .pkt_valid   (pkt_valid),
    .push_ok     (push_ok),
    .pop_ok      (pop_ok)
  );

  epbuf_tf_seq #(.TF_N(TF_N), .EXCL_A(EXCL_A), .EXCL_B(EXCL_B)) tf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (exec_op == OP_TFREAD),
    .busy    (tf_busy),
    .irq     (irq),
    .tf_addr (tf_addr)
  );

  assign tf_rd    = tf_busy;
  assign cmd_busy = tf_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_mode    <= '0;
      dma_dir     <= 1'b0;
      dma_armed   <= 1'b0;
      illegal_cmd <= 1'b0;
    end else begin
      case (exec_op)
        OP_MODE: begin
          dma_mode  <= exec_code[2:1];
          dma_dir   <= exec_code[0];
          dma_armed <= 1'b1;
        end
        OP_DMARST: begin
          dma_mode    <= '0;
          dma_dir     <= 1'b0;
          dma_armed   <= 1'b0;
          illegal_cmd <= 1'b0;
        end
        OP_ILLEGAL: illegal_cmd <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/epbuf_cmd_ctrl_chk.sv
module epbuf_cmd_ctrl_chk
  import epbuf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TF_N   = 8,
  parameter int EXCL_A = 0,
  parameter int EXCL_B = 7,
  localparam int AW    = $clog2(DEPTH),
  localparam int TF_AW = $clog2(TF_N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_exec,
  input op_e              exec_op,
  input logic             tf_busy,
  input logic             irq,
  input logic             tf_rd,
  input logic [TF_AW-1:0] tf_addr,
  input logic [AW-1:0]    wr_ptr,
  input logic [AW-1:0]    rd_ptr,
  input logic [AW:0]      level,
  input logic             pkt_valid,
  input logic             illegal_cmd
);
  p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));

  p_valid_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> level != '0);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec && exec_op == OP_CLEAR) |=>
      (level == '0 && !pkt_valid && wr_ptr == '0 && rd_ptr == '0));

  p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec && exec_op == OP_RESTART) |=>
      (wr_ptr == '0 && rd_ptr == '0 && pkt_valid == $past(pkt_valid)));

  p_dmarst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec && exec_op == OP_DMARST) |=>
      (level == '0 && !pkt_valid && !illegal_cmd));

  p_tf_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tf_rd |-> (int'(tf_addr) != EXCL_A && int'(tf_addr) != EXCL_B));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tf_busy) |-> irq);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tf_busy |-> !cmd_exec);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_cmd && !(cmd_exec && exec_op == OP_DMARST)) |=> illegal_cmd);

  p_cmd_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec && exec_op != OP_CLEAR && exec_op != OP_DMARST) |=> $stable(level));
endmodule

bind epbuf_cmd_ctrl epbuf_cmd_ctrl_chk #(
  .DEPTH(DEPTH), .TF_N(TF_N), .EXCL_A(EXCL_A), .EXCL_B(EXCL_B)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_exec    (cmd_exec),
  .exec_op     (exec_op),
  .tf_busy     (tf_busy),
  .irq         (irq),
  .tf_rd       (tf_rd),
  .tf_addr     (tf_addr),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .level       (level),
  .pkt_valid   (pkt_valid),
  .illegal_cmd (illegal_cmd)
);

// File: tb/epbuf_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module epbuf_cmd_ctrl_tb_top;
  localparam int DW = 8;
  localparam int DP = 4;
  localparam int TN = 8;
  localparam int XA = 0;
  localparam int XB = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_code = '0;
  logic       push_en = 1'b0;
  logic [7:0] push_data = '0;
  logic       pop_en = 1'b0;
  logic       cmd_busy, pkt_valid, tf_rd, irq, dma_dir, dma_armed, illegal_cmd;
  logic [7:0] pop_data;
  logic [1:0] wr_ptr, rd_ptr, dma_mode;
  logic [2:0] level;
  logic [2:0] tf_addr;

  always #2.5 clk = ~clk;

  epbuf_cmd_ctrl #(.DATA_W(DW), .DEPTH(DP), .TF_N(TN), .EXCL_A(XA), .EXCL_B(XB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .cmd_busy(cmd_busy),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en), .pop_data(pop_data),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level), .pkt_valid(pkt_valid),
    .tf_rd(tf_rd), .tf_addr(tf_addr), .irq(irq), .dma_mode(dma_mode),
    .dma_dir(dma_dir), .dma_armed(dma_armed), .illegal_cmd(illegal_cmd)
  );

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  // Reference FIFO state, kept arithmetically.
  int mmem [DP];
  int mwp = 0, mrp = 0, mlvl = 0, mval = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_fifo(input string req);
    chk(req, "wr_ptr", int'(wr_ptr), mwp);
    chk(req, "rd_ptr", int'(rd_ptr), mrp);
    chk(req, "level", int'(level), mlvl);
    chk(req, "pkt_valid", int'(pkt_valid), mval);
  endtask

  task automatic do_cmd(input logic [7:0] c);
    cmd_wr = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic do_push(input int d);
    push_en = 1'b1; push_data = 8'(d);
    @(negedge clk);
    push_en = 1'b0;
    if (mlvl < DP) begin
      mmem[mwp] = d; mwp = (mwp + 1) % DP; mlvl++;
    end
  endtask

  task automatic do_pop(input string req);
    if (mlvl > 0) chk(req, "pop_data", int'(pop_data), mmem[mrp]);
    pop_en = 1'b1;
    @(negedge clk);
    pop_en = 1'b0;
    if (mlvl > 0) begin
      mrp = (mrp + 1) % DP; mlvl--;
      if (mlvl == 0) mval = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_fifo("R1");
    chk("R1", "tf_rd", int'(tf_rd), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "cmd_busy", int'(cmd_busy), 0);
    chk("R1", "dma_mode", int'(dma_mode), 0);
    chk("R1", "dma_dir", int'(dma_dir), 0);
    chk("R1", "dma_armed", int'(dma_armed), 0);
    chk("R1", "illegal_cmd", int'(illegal_cmd), 0);

    // R2 fill past full, drain with wrap, pop on empty
    for (int i = 0; i < DP + 1; i++) begin
      do_push(8'hA0 + i);
      chk_fifo("R2");
    end
    do_pop("R2"); do_pop("R2");
    chk_fifo("R2");
    do_push(8'h51); do_push(8'h52);
    chk_fifo("R2");
    for (int i = 0; i < DP + 1; i++) begin
      do_pop("R2");
      chk_fifo("R2");
    end

    // R3 validate, then drain clears the flag; validate on empty
    do_push(8'h11); do_push(8'h22);
    chk_fifo("R3");
    do_cmd(8'h0E); mval = 1;
    chk_fifo("R3");
    do_pop("R3"); chk_fifo("R3");
    do_pop("R3"); chk_fifo("R3");
    do_cmd(8'h0E);
    chk_fifo("R3");

    // R5 rewind keeps data, level and flag
    do_cmd(8'h0F); mwp = 0; mrp = 0; mlvl = 0; mval = 0;
    do_push(8'h31); do_push(8'h32); do_push(8'h33);
    do_cmd(8'h0E); mval = 1;
    do_pop("R5");
    do_cmd(8'h10); mwp = 0; mrp = 0;
    chk_fifo("R5");
    do_pop("R5"); do_pop("R5");
    chk_fifo("R5");

    // R4 clear
    do_cmd(8'h0F); mwp = 0; mrp = 0; mlvl = 0; mval = 0;
    chk_fifo("R4");

    // R12 push and pop alongside a command are dropped
    do_push(8'h41);
    cmd_wr = 1'b1; cmd_code = 8'h01; push_en = 1'b1; push_data = 8'h99; pop_en = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; push_en = 1'b0; pop_en = 1'b0;
    chk_fifo("R12");
    chk("R12", "pop_data", int'(pop_data), 8'h41);
    chk("R12", "dma_dir", int'(dma_dir), 1);

    // R7 every mode code
    for (int c = 0; c < 8; c++) begin
      do_cmd(8'(c));
      chk("R7", "dma_mode", int'(dma_mode), c / 2);
      chk("R7", "dma_dir", int'(dma_dir), c % 2);
      chk("R7", "dma_armed", int'(dma_armed), 1);
    end

    // R11 every reserved code: no state change, sticky flag
    do_push(8'h42);
    do_cmd(8'h0E); mval = 1;
    do_cmd(8'h05);
    for (int c = 0; c < 256; c++) begin
      if (c < 8 || c == 8'h0C || c == 8'h0E || c == 8'h0F || c == 8'h10 || c == 8'h11) continue;
      do_cmd(8'(c));
      chk("R11", "illegal_cmd", int'(illegal_cmd), 1);
      chk("R11", "level", int'(level), mlvl);
      chk("R11", "pkt_valid", int'(pkt_valid), mval);
      chk("R11", "dma_mode", int'(dma_mode), 2);
    end
    do_cmd(8'h03);
    chk("R11", "illegal_cmd after legal", int'(illegal_cmd), 1);

    // R6 DMA reset
    do_cmd(8'h11); mwp = 0; mrp = 0; mlvl = 0; mval = 0;
    chk_fifo("R6");
    chk("R6", "dma_mode", int'(dma_mode), 0);
    chk("R6", "dma_dir", int'(dma_dir), 0);
    chk("R6", "dma_armed", int'(dma_armed), 0);
    chk("R6", "illegal_cmd", int'(illegal_cmd), 0);

    // R8 R9 R10 task-file sweep with held commands
    cmd_wr = 1'b1; cmd_code = 8'h0C;
    @(negedge clk);
    cmd_wr = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk("R8", "tf_rd", int'(tf_rd), 1);
      chk("R8", "cmd_busy", int'(cmd_busy), 1);
      chk("R8", "tf_addr", int'(tf_addr), i + 1);
      chk("R9", "irq low during sweep", int'(irq), 0);
      if (i == 1) begin cmd_wr = 1'b1; cmd_code = 8'h0D; end
      if (i == 2) begin cmd_wr = 1'b1; cmd_code = 8'h03; end
      if (i == 3) cmd_wr = 1'b0;
      @(negedge clk);
    end
    chk("R9", "irq", int'(irq), 1);
    chk("R9", "tf_rd", int'(tf_rd), 0);
    chk("R9", "cmd_busy", int'(cmd_busy), 0);
    chk("R10", "dma_armed held", int'(dma_armed), 0);
    @(negedge clk);
    chk("R9", "irq single", int'(irq), 0);
    chk("R10", "dma_mode", int'(dma_mode), 1);
    chk("R10", "dma_dir", int'(dma_dir), 1);
    chk("R10", "dma_armed", int'(dma_armed), 1);
    chk("R10", "illegal_cmd overwritten", int'(illegal_cmd), 0);
    chk_fifo("R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule